// File: doc/BRIEF.md
# PHY Control-Port Write Master

This block writes one 16-bit value into one 16-bit internal PHY register through a narrow control port. The port has a single shared 16-bit data-in bus, three strobes (capture-address, capture-data, write), a read strobe, and an acknowledge line that comes back from the PHY. The block splits each register write into three four-phase handshakes in a fixed order. First it captures the address. Then it captures the data. Last, it commits the write.

Before a handshake starts, the value for that handshake sits on the bus for one cycle with every strobe low. The strobe then rises and stays high until the acknowledge rises. It then drops, while the bus value is held, until the acknowledge falls. A cycle counter bounds each of the two acknowledge waits separately. If a wait runs out, the write stops at once. The block then reports which handshake failed and whether the rising or the falling edge of the acknowledge was missing.

The host side is a request/busy/done interface. A request carries an address and a data word and is taken only while the block is idle. At the end of every write, done pulses for one cycle together with the error outcome.

Top module: `crp_write_master`

## Requirements
- R1: After reset, all strobes are low, the data-in bus is zero, and busy and done are low.
- R2: A request is accepted only while busy is low. A request raised while busy is high is ignored: it produces no extra handshake and no extra done.
- R3: After acceptance, the address is on data-in with no strobe high for at least one cycle. The capture-address strobe then rises with the address still on the bus.
- R4: After the address handshake, the data word is placed on data-in for one cycle with no strobe high. The capture-data strobe then rises. After that handshake, the write strobe rises with the same data word still on the bus. Capture-data never rises before capture-address, and write never rises before capture-data.
- R5: Each strobe stays high until the acknowledge is seen high. The strobe then falls, and data-in does not change in the cycle it falls. The handshake ends when the acknowledge is seen low.
- R6: If the acknowledge stays low for TMO_CYCLES cycles with a strobe high, the strobe drops and done pulses in the same cycle. It carries err=1, err_kind=1 (rise missing) and err_stage set to the failing handshake (0 address, 1 data, 2 write).
- R7: If the acknowledge stays high for TMO_CYCLES cycles after a strobe fell, done pulses with err=1 and err_kind=2 (fall missing). err_stage is coded as in R6.
- R8: An acknowledge edge first seen in the last cycle of its wait window counts as success, not as a timeout.
- R9: After a failed handshake, no further strobe of that write rises.
- R10: done is a one-cycle pulse, and busy is low in that cycle. A successful write reports err=0 and err_kind=0.
- R11: The read strobe is never asserted.
- R12: At most one strobe is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Write request, taken when busy is low |
| req_addr | input | 16 | PHY register address |
| req_data | input | 16 | Value to write |
| busy | output | 1 | A write is in progress |
| done | output | 1 | One-cycle end-of-write pulse |
| err | output | 1 | Write failed (valid with done) |
| err_kind | output | 2 | 0 none, 1 rise timeout, 2 fall timeout |
| err_stage | output | 2 | Failing handshake: 0 address, 1 data, 2 write |
| phy_din | output | 16 | Shared address/data bus to the PHY |
| phy_cap_addr | output | 1 | Capture-address strobe |
| phy_cap_data | output | 1 | Capture-data strobe |
| phy_wr | output | 1 | Write-commit strobe |
| phy_rd | output | 1 | Read strobe, held low |
| phy_ack | input | 1 | Acknowledge from the PHY |

## Verification
The acknowledge edge and the expiry of the wait counter can fall in the same cycle. When that happens the edge must win. To provoke this, the bench responder delays the acknowledge by exactly TMO_CYCLES cycles, on the rising edge in one handshake and on the falling edge in another. The bench expects both writes to complete with no error. One cycle more of delay must instead produce the matching timeout code, and the bench judges this by counting how long the strobe was high or the acknowledge lingered. A strobe fall and the done pulse also share a cycle on a rise timeout. The bench checks that case, and it checks that no later strobe follows it.

// File: rtl/crp_pkg.sv
package crp_pkg;
  localparam int NSTB = 3;

  typedef enum logic [1:0] {
    STG_ADDR  = 2'd0,
    STG_DATA  = 2'd1,
    STG_WRITE = 2'd2
  } stage_t;

  typedef enum logic [1:0] {
    ERR_NONE = 2'd0,
    ERR_RISE = 2'd1,
    ERR_FALL = 2'd2
  } errkind_t;
endpackage

// File: rtl/crp_wait_timer.sv
module crp_wait_timer #(
  parameter int TMO_CYCLES = 1000
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  output logic expire
);
  localparam int CW = $clog2(TMO_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(TMO_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  assign expire = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst || clr) cnt_q <= '0;
    else if (!expire) cnt_q <= cnt_q + CW'(1);
  end
endmodule

// File: rtl/crp_handshake.sv
module crp_handshake
  import crp_pkg::*;
#(
  parameter int TMO_CYCLES = 1000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  stage_t          sel,
  input  logic            ack,
  output logic [NSTB-1:0] strobes,
  output logic            ok,
  output logic            fail,
  output errkind_t        fail_kind
);
  typedef enum logic [1:0] {HS_IDLE, HS_RISE, HS_FALL} hs_t;

  hs_t             st_q;
  logic [NSTB-1:0] stb_q;
  logic            expire;
  logic            tclr;

  assign tclr = (st_q == HS_IDLE) || (st_q == HS_RISE && ack);

  crp_wait_timer #(.TMO_CYCLES(TMO_CYCLES)) u_tmr (
    .clk    (clk),
    .rst    (rst),
    .clr    (tclr),
    .expire (expire)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= HS_IDLE;
      stb_q <= '0;
    end else begin
      case (st_q)
        HS_IDLE: if (start) begin
          st_q  <= HS_RISE;
          stb_q <= NSTB'(1) << sel;
        end
        HS_RISE: if (ack) begin
          st_q  <= HS_FALL;
          stb_q <= '0;
        end else if (expire) begin
          st_q  <= HS_IDLE;
          stb_q <= '0;
        end
        HS_FALL: if (!ack || expire) st_q <= HS_IDLE;
        default: st_q <= HS_IDLE;
      endcase
    end
  end

  assign strobes   = stb_q;
  assign ok        = (st_q == HS_FALL) && !ack;
  assign fail      = ((st_q == HS_RISE) && !ack && expire) ||
                     ((st_q == HS_FALL) && ack && expire);
  assign fail_kind = (st_q == HS_RISE) ? ERR_RISE : ERR_FALL;
endmodule

// File: rtl/crp_sequencer.sv
module crp_sequencer
  import crp_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  input  logic          hs_ok,
  input  logic          hs_fail,
  input  errkind_t      hs_fail_kind,
  output logic          hs_start,
  output stage_t        hs_sel,
  output logic [DW-1:0] din,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [1:0]    err_kind,
  output logic [1:0]    err_stage
);
  localparam int BW = (AW > DW) ? AW : DW;

  typedef enum logic [1:0] {SQ_IDLE, SQ_SETUP, SQ_WAIT} sq_t;

  sq_t           st_q;
  stage_t        stg_q;
  logic [DW-1:0] data_q;
  logic [DW-1:0] din_q;
  logic          busy_q, done_q, err_q;
  errkind_t      kind_q;
  stage_t        estg_q;
  logic [BW-1:0] addr_ext;

  assign addr_ext = BW'(req_addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= SQ_IDLE;
      stg_q  <= STG_ADDR;
      data_q <= '0;
      din_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      kind_q <= ERR_NONE;
      estg_q <= STG_ADDR;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        SQ_IDLE: if (req_valid) begin
          data_q <= req_data;
          din_q  <= DW'(addr_ext);
          stg_q  <= STG_ADDR;
          busy_q <= 1'b1;
          st_q   <= SQ_SETUP;
        end
        SQ_SETUP: st_q <= SQ_WAIT;
        SQ_WAIT: begin
          if (hs_fail) begin
            st_q   <= SQ_IDLE;
            busy_q <= 1'b0;
            done_q <= 1'b1;
            err_q  <= 1'b1;
            kind_q <= hs_fail_kind;
            estg_q <= stg_q;
          end else if (hs_ok) begin
            if (stg_q == STG_WRITE) begin
              st_q   <= SQ_IDLE;
              busy_q <= 1'b0;
              done_q <= 1'b1;
              err_q  <= 1'b0;
              kind_q <= ERR_NONE;
              estg_q <= STG_ADDR;
            end else begin
              stg_q <= (stg_q == STG_ADDR) ? STG_DATA : STG_WRITE;
              din_q <= data_q;
              st_q  <= SQ_SETUP;
            end
          end
        end
        default: st_q <= SQ_IDLE;
      endcase
    end
  end

  assign hs_start  = (st_q == SQ_SETUP);
  assign hs_sel    = stg_q;
  assign din       = din_q;
  assign busy      = busy_q;
  assign done      = done_q;
  assign err       = err_q;
  assign err_kind  = kind_q;
  assign err_stage = estg_q;
endmodule

// File: rtl/crp_write_master.sv
module crp_write_master
  import crp_pkg::*;
#(
  parameter int AW         = 16,
  parameter int DW         = 16,
  parameter int US_DIV     = 10,
  parameter int TMO_CYCLES = 100 * US_DIV
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic [1:0]    err_kind,
  output logic [1:0]    err_stage,
  output logic [DW-1:0] phy_din,
  output logic          phy_cap_addr,
  output logic          phy_cap_data,
  output logic          phy_wr,
  output logic          phy_rd,
  input  logic          phy_ack
);
  logic            hs_start, hs_ok, hs_fail;
  stage_t          hs_sel;
  errkind_t        hs_kind;
  logic [NSTB-1:0] stb;

  crp_sequencer #(.AW(AW), .DW(DW)) u_seq (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_addr     (req_addr),
    .req_data     (req_data),
    .hs_ok        (hs_ok),
    .hs_fail      (hs_fail),
    .hs_fail_kind (hs_kind),
    .hs_start     (hs_start),
    .hs_sel       (hs_sel),
    .din          (phy_din),
    .busy         (busy),
    .done         (done),
    .err          (err),
    .err_kind     (err_kind),
    .err_stage    (err_stage)
  );

  crp_handshake #(.TMO_CYCLES(TMO_CYCLES)) u_hs (
    .clk       (clk),
    .rst       (rst),
    .start     (hs_start),
    .sel       (hs_sel),
    .ack       (phy_ack),
    .strobes   (stb),
    .ok        (hs_ok),
    .fail      (hs_fail),
    .fail_kind (hs_kind)
  );

  assign phy_cap_addr = stb[STG_ADDR];
  assign phy_cap_data = stb[STG_DATA];
  assign phy_wr       = stb[STG_WRITE];
  assign phy_rd       = 1'b0;
endmodule

// File: rtl/crp_write_master_chk.sv
module crp_write_master_chk #(
  parameter int DW         = 16,
  parameter int TMO_CYCLES = 1000
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          done,
  input logic          err,
  input logic [1:0]    err_kind,
  input logic [DW-1:0] phy_din,
  input logic          phy_cap_addr,
  input logic          phy_cap_data,
  input logic          phy_wr
);
  logic [2:0] stb;
  logic       any_stb;
  int         hi_cnt;
  logic [1:0] last_q;

  assign stb     = {phy_wr, phy_cap_data, phy_cap_addr};
  assign any_stb = |stb;

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_cnt <= 0;
      last_q <= 2'd3;
    end else begin
      hi_cnt <= any_stb ? hi_cnt + 1 : 0;
      if (phy_cap_addr) last_q <= 2'd0;
      else if (phy_cap_data) last_q <= 2'd1;
      else if (phy_wr) last_q <= 2'd2;
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst) $onehot0(stb)); // R12
  AST_STROBE_BUSY: assert property (@(posedge clk) disable iff (rst) any_stb |-> busy); // R3
  AST_HOLD_ON_FALL: assert property (@(posedge clk) disable iff (rst) $fell(any_stb) |-> $stable(phy_din)); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R10
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst) done |-> !busy); // R10
  AST_RISE_BOUND: assert property (@(posedge clk) disable iff (rst) hi_cnt <= TMO_CYCLES); // R6
  AST_ERR_CODED: assert property (@(posedge clk) disable iff (rst) (done && err) |-> (err_kind != 2'd0)); // R7
  AST_OK_CLEAN: assert property (@(posedge clk) disable iff (rst) (done && !err) |-> (err_kind == 2'd0)); // R10
  AST_NO_STB_AFTER_FAIL: assert property (@(posedge clk) disable iff (rst) (done && err) |=> !any_stb); // R9
  AST_DATA_AFTER_ADDR: assert property (@(posedge clk) disable iff (rst) $rose(phy_cap_data) |-> (last_q == 2'd0)); // R4
  AST_WR_AFTER_DATA: assert property (@(posedge clk) disable iff (rst) $rose(phy_wr) |-> (last_q == 2'd1)); // R4
endmodule

bind crp_write_master crp_write_master_chk #(.DW(DW), .TMO_CYCLES(TMO_CYCLES)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .busy         (busy),
  .done         (done),
  .err          (err),
  .err_kind     (err_kind),
  .phy_din      (phy_din),
  .phy_cap_addr (phy_cap_addr),
  .phy_cap_data (phy_cap_data),
  .phy_wr       (phy_wr)
);

// File: tb/sim_crp_write_master.sv
`timescale 1ns/1ps
module sim_crp_write_master;
  localparam int US_DIV = 2;
  localparam int TMO    = 100 * US_DIV;
  localparam int NEVER  = 1000000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [15:0] req_addr = '0, req_data = '0;
  logic        busy, done, err;
  logic [1:0]  err_kind, err_stage;
  logic [15:0] phy_din;
  logic        phy_cap_addr, phy_cap_data, phy_wr, phy_rd;
  logic        phy_ack = 1'b0;

  always #4 clk = ~clk;

  crp_write_master #(.US_DIV(US_DIV)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
    .req_data(req_data), .busy(busy), .done(done), .err(err),
    .err_kind(err_kind), .err_stage(err_stage), .phy_din(phy_din),
    .phy_cap_addr(phy_cap_addr), .phy_cap_data(phy_cap_data),
    .phy_wr(phy_wr), .phy_rd(phy_rd), .phy_ack(phy_ack)
  );

  int vectors = 0, miscompares = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  typedef struct { logic [2:0] sel; logic [15:0] din; } ev_t;
  typedef struct { logic err; logic [1:0] kind; logic [1:0] stage; } res_t;
  ev_t  ev_q[$];
  res_t res_q[$];

  // Responder: per-stage ack delays counted in negedges
  int rdly[3], fdly[3];
  int r_hi = 0, r_lo = 0, r_idx = 0;
  always @(negedge clk) begin
    if (phy_cap_addr | phy_cap_data | phy_wr) begin
      r_idx = phy_wr ? 2 : (phy_cap_data ? 1 : 0);
      r_lo = 0;
      r_hi++;
      if (r_hi >= rdly[r_idx]) phy_ack = 1'b1;
    end else begin
      r_hi = 0;
      if (phy_ack) begin
        r_lo++;
        if (r_lo >= fdly[r_idx]) begin phy_ack = 1'b0; r_lo = 0; end
      end
    end
  end

  // Monitor / scoreboard
  logic [2:0]  stb_prev = '0;
  logic [15:0] din_prev = '0;
  logic        done_prev = 1'b0;
  int hi_cnt = 0, last_hi = 0, lo_cnt = 0;
  bit multi = 0, rd_seen = 0;
  always @(negedge clk) begin
    if (!rst) begin
      automatic logic [2:0] stb = {phy_wr, phy_cap_data, phy_cap_addr};
      automatic bit fell = (stb == 0) && (stb_prev != 0);
      if ($countones(stb) > 1) multi = 1;
      if (phy_rd) rd_seen = 1;
      if (stb != 0 && stb_prev == 0) begin
        if (ev_q.size() == 0) check(0, "R9 unexpected strobe", stb, 0);
        else begin
          automatic ev_t e = ev_q.pop_front();
          automatic string t = (e.sel == 3'b001) ? "R3" : "R4";
          check(stb == e.sel, {t, " strobe order"}, stb, e.sel);
          check(phy_din == e.din, {t, " bus value at strobe"}, phy_din, e.din);
          if (e.sel != 3'b100)
            check(din_prev == e.din, {t, " setup cycle value"}, din_prev, e.din);
        end
        hi_cnt = 1;
      end else if (stb != 0) hi_cnt++;
      if (fell) begin
        check(phy_din == din_prev, "R5 bus held at strobe fall", phy_din, din_prev);
        last_hi = hi_cnt;
      end
      if (done) begin
        check(!busy, "R10 busy low with done", busy, 0);
        if (res_q.size() == 0) check(0, "R2 unexpected done", 1, 0);
        else begin
          automatic res_t r = res_q.pop_front();
          check(err == r.err, "R10 err flag", err, r.err);
          check(err_kind == r.kind, "R6 R7 err_kind", err_kind, r.kind);
          if (r.err) check(err_stage == r.stage, "R6 err_stage", err_stage, r.stage);
          if (r.kind == 2'd1) check(last_hi == TMO, "R6 strobe high cycles", last_hi, TMO);
          if (r.kind == 2'd2) check(lo_cnt == TMO, "R7 ack linger cycles", lo_cnt, TMO);
        end
        check(!rd_seen, "R11 read strobe", rd_seen, 0);
        check(!multi, "R12 single strobe", multi, 0);
      end
      if (done && done_prev) check(0, "R10 done longer than one cycle", 2, 1);
      if (fell) lo_cnt = 1;
      else if (stb == 0) lo_cnt++;
      stb_prev  = stb;
      din_prev  = phy_din;
      done_prev = done;
    end
  end

  task automatic set_dly(input int r0, f0, r1, f1, r2, f2);
    rdly[0] = r0; fdly[0] = f0; rdly[1] = r1; fdly[1] = f1; rdly[2] = r2; fdly[2] = f2;
  endtask

  // fail_stage 3 = success
  task automatic do_write(input logic [15:0] a, d, input int fail_stage, input logic [1:0] kind,
                          input bit poke_busy);
    ev_t e; res_t r;
    e.sel = 3'b001; e.din = a; ev_q.push_back(e);
    if (fail_stage > 0) begin e.sel = 3'b010; e.din = d; ev_q.push_back(e); end
    if (fail_stage > 1) begin e.sel = 3'b100; e.din = d; ev_q.push_back(e); end
    r.err = (fail_stage < 3); r.kind = kind; r.stage = 2'(fail_stage);
    res_q.push_back(r);
    @(negedge clk);
    while (busy) @(negedge clk);
    req_addr = a; req_data = d; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (poke_busy) begin
      repeat (3) @(negedge clk);
      req_addr = ~a; req_data = ~d; req_valid = 1'b1;
      repeat (2) @(negedge clk);
      req_valid = 1'b0;
    end
    while (!done) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic settle();
    set_dly(1, 1, 1, 1, 1, 1);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    set_dly(1, 1, 1, 1, 1, 1);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!phy_cap_addr && !phy_cap_data && !phy_wr, "R1 strobes low", {phy_wr, phy_cap_data, phy_cap_addr}, 0);
    check(phy_din == 16'h0, "R1 bus zero", phy_din, 0);
    check(!busy && !done, "R1 busy/done low", {busy, done}, 0);

    do_write(16'h0015, 16'hA009, 3, 2'd0, 0);
    set_dly(3, 5, 2, 4, 6, 1);
    do_write(16'h1010, 16'h0080, 3, 2'd0, 0);
    set_dly(1, 1, TMO, 1, 1, TMO);                 // R8 edges on last cycle
    do_write(16'h0012, 16'hA000, 3, 2'd0, 0);
    settle();
    set_dly(TMO + 1, 1, 1, 1, 1, 1);               // R6 address rise timeout
    do_write(16'hFFFF, 16'h5555, 0, 2'd1, 0);
    settle();
    set_dly(1, 1, 1, NEVER, 1, 1);                 // R7 data fall timeout
    do_write(16'h00AA, 16'h1234, 1, 2'd2, 0);
    settle();
    set_dly(2, 2, 2, 2, TMO + 1, 1);               // R6 write rise timeout
    do_write(16'h0101, 16'hFEDC, 2, 2'd1, 0);
    settle();
    do_write(16'h0033, 16'h0CC0, 3, 2'd0, 1);      // R2 request while busy
    repeat (10) @(negedge clk);
    check(ev_q.size() == 0, "R9 no missing strobe", ev_q.size(), 0);
    check(res_q.size() == 0, "R2 no missing done", res_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    vectors++;
    miscompares++;
    $display("FAIL watchdog expired actual=hang expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule